// File: doc/BRIEF.md
# Power Domain Switch Sequencer

This block turns one of ten non-CPU power domains on or off on behalf of a requester. It takes a request made of a domain index and an on/off flag. The request becomes a single command bit for a power management engine. The block then polls until the engine confirms the change, and ends the request with a one-cycle `done` or `err` pulse.

An enable flag (`ctrl_en`) is raised before the command is driven and is dropped once the outcome is known. The engine must do three things for a request to complete: echo the command bit on `ack_vec`, and show the requested state on both the primary and the secondary status vectors, at a bit position fixed for each domain. The poll is spaced by a prescaler of `POLL_CYCLES` clock cycles. A poll counter gives up once the number of failed samples exceeds `MAX_POLLS`.

The request side is a valid/ready interface:
- `req_ready` is high only while the block is idle.
- A request is accepted on a cycle where `req_valid` and `req_ready` are both high.
- `req_valid` raised while `req_ready` is low is dropped, not queued. A requester that wants its request taken must hold `req_valid` until it sees `req_ready`.

The engine-side vectors and the result pulses are plain signals with no handshake.

Top module: `pwr_domain_seq`

## Requirements
- R1: `req_ready` is 1 exactly when no request is in progress. A `req_valid` pulse while `req_ready` is 0 has no effect on `cmd_vec`, `ctrl_en` or the outcome of the request in progress.
- R2: `cmd_vec` (20 bits) is zero or one-hot. For domain d (0..9), a power-on request drives bit d and a power-off request drives bit d+10.
- R3: `ctrl_en` goes to 1 one cycle after acceptance, while `cmd_vec` is still zero. `cmd_vec` takes the command one cycle after that. `ctrl_en` stays 1 until the cycle in which the outcome pulse appears, and falls in that cycle.
- R4: The status bit checked for domains 0,1,2,...,9 is, in that order, bit 7, 21, 5, 3, 20, 24, 23, 22, 4, 25 of `sta_pri` and `sta_sec`. No other status bit affects the result.
- R5: A sample succeeds only if all three hold: `ack_vec & cmd_vec` is non-zero, `sta_pri` at the domain's position equals `req_on`, and `sta_sec` at that position equals `req_on`.
- R6: Sample n (n = 1, 2, ...) is taken at the clock edge `n*POLL_CYCLES` cycles after `cmd_vec` first shows the command. After a successful sample n, `done` is high in the cycle that follows that edge.
- R7: If samples 1 to `MAX_POLLS+1` all fail, `err` is high in the cycle that follows sample `MAX_POLLS+1`.
- R8: In the cycle of the `done` or `err` pulse, `cmd_vec` is zero and `ctrl_en` is 0. Each pulse lasts one cycle, and `done` and `err` are never high together.
- R9: A request with a domain index of 10..15 raises `err` in the cycle after acceptance and never sets `cmd_vec` or `ctrl_en`.
- R10: After reset, `req_ready` is 1 and `cmd_vec`, `ctrl_en`, `done` and `err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_dom | input | 4 | Domain index (0..9 valid) |
| req_on | input | 1 | 1 = power on, 0 = power off |
| ack_vec | input | 20 | Command echo from the power engine |
| sta_pri | input | 32 | Primary domain status vector |
| sta_sec | input | 32 | Secondary domain status vector |
| cmd_vec | output | 20 | One-hot command to the power engine |
| ctrl_en | output | 1 | Engine control enable |
| done | output | 1 | One-cycle success pulse |
| err | output | 1 | One-cycle failure pulse (timeout or bad index) |

## Verification
The schedule below counts from the acceptance edge, the edge at which `req_valid` and `req_ready` are both high:

| Result | When it is checked |
|---|---|
| `ctrl_en` | one cycle after acceptance |
| command bit on `cmd_vec` | two cycles after acceptance |
| `done` or `err` | exactly `n*POLL_CYCLES` cycles after the command appeared, where n is the index of the deciding sample |
| `err` for an out-of-range index | one cycle after acceptance |

The bench counts cycles from the acceptance edge and samples one time unit after each rising edge. For every request it derives, from the scenario it set up, the sample index at which the outcome is due. It checks that no pulse appears before that cycle, checks the expected pulse in that cycle, and checks that the pulse has gone one cycle later. In late-acknowledge cases it changes the engine inputs right after a chosen sample edge, so the result lands on the next sample and not earlier.

// File: rtl/pds_pkg.sv
package pds_pkg;
  localparam int NDOM      = 10;
  localparam int CMD_W     = 2 * NDOM;
  localparam int IDX_W     = 4;
  localparam int STA_W     = 32;
  localparam int STA_POS_W = 5;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_WAIT = 2'd2
  } pds_state_e;

  // Status bit position checked for each domain; the power engine fixes this map.
  function automatic logic [STA_POS_W-1:0] sta_pos(input int unsigned d);
    case (d)
      0:       return 5'd7;
      1:       return 5'd21;
      2:       return 5'd5;
      3:       return 5'd3;
      4:       return 5'd20;
      5:       return 5'd24;
      6:       return 5'd23;
      7:       return 5'd22;
      8:       return 5'd4;
      9:       return 5'd25;
      default: return 5'd0;
    endcase
  endfunction
endpackage

// File: rtl/pds_decode.sv
module pds_decode
  import pds_pkg::*;
(
  input  logic [IDX_W-1:0]     dom,
  input  logic                 on,
  output logic                 in_range,
  output logic [CMD_W-1:0]     cmd,
  output logic [STA_POS_W-1:0] pos
);
  logic [NDOM-1:0] sel;

  for (genvar g = 0; g < NDOM; g++) begin : g_sel
    assign sel[g] = (dom == IDX_W'(g));
  end

  always_comb begin
    in_range = |sel;
    cmd      = '0;
    pos      = '0;
    for (int i = 0; i < NDOM; i++) begin
      if (sel[i]) begin
        if (on) cmd[i]      = 1'b1;
        else    cmd[i+NDOM] = 1'b1;
        pos = pos | sta_pos(i);
      end
    end
  end
endmodule

// File: rtl/pds_match.sv
module pds_match
  import pds_pkg::*;
(
  input  logic [CMD_W-1:0]     ack,
  input  logic [CMD_W-1:0]     cmd,
  input  logic [STA_W-1:0]     pri,
  input  logic [STA_W-1:0]     sec,
  input  logic [STA_POS_W-1:0] pos,
  input  logic                 on,
  output logic                 hit
);
  logic echo_ok, pri_ok, sec_ok;

  always_comb begin
    echo_ok = |(ack & cmd);
    pri_ok  = (pri[pos] == on);
    sec_ok  = (sec[pos] == on);
    hit     = echo_ok && pri_ok && sec_ok;
  end
endmodule

// File: rtl/pds_poll_timer.sv
module pds_poll_timer #(
  parameter int POLL_CYCLES = 1000,
  parameter int MAX_POLLS   = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick,
  output logic last
);
  localparam int PRE_W = (POLL_CYCLES > 1) ? $clog2(POLL_CYCLES) : 1;
  localparam int CNT_W = $clog2(MAX_POLLS + 1);

  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] polls_q;

  assign tick = run && (pre_q == PRE_W'(POLL_CYCLES - 1));
  assign last = (polls_q == CNT_W'(MAX_POLLS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q   <= '0;
      polls_q <= '0;
    end else if (!run) begin
      pre_q   <= '0;
      polls_q <= '0;
    end else begin
      pre_q <= tick ? '0 : pre_q + 1'b1;
      if (tick && !last) polls_q <= polls_q + 1'b1;
    end
  end

  // R7: failed-sample count never passes its limit
  a_r7_poll_bound: assert property (@(posedge clk) disable iff (!rst_n)
    polls_q <= CNT_W'(MAX_POLLS));
  // R6: prescaler stays inside one poll interval
  a_r6_pre_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pre_q <= PRE_W'(POLL_CYCLES - 1));
endmodule

// File: rtl/pwr_domain_seq.sv
module pwr_domain_seq
  import pds_pkg::*;
#(
  parameter int POLL_CYCLES = 1000,
  parameter int MAX_POLLS   = 10000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [3:0]       req_dom,
  input  logic             req_on,
  input  logic [19:0]      ack_vec,
  input  logic [31:0]      sta_pri,
  input  logic [31:0]      sta_sec,
  output logic [19:0]      cmd_vec,
  output logic             ctrl_en,
  output logic             done,
  output logic             err
);
  pds_state_e           state_q;
  logic [CMD_W-1:0]     cmd_q, pend_q;
  logic [STA_POS_W-1:0] pos_q;
  logic                 on_q, en_q, done_q, err_q;

  logic                 dec_ok;
  logic [CMD_W-1:0]     dec_cmd;
  logic [STA_POS_W-1:0] dec_pos;
  logic                 hit, tick, last, accept;

  pds_decode u_dec (
    .dom      (req_dom),
    .on       (req_on),
    .in_range (dec_ok),
    .cmd      (dec_cmd),
    .pos      (dec_pos)
  );

  pds_match u_match (
    .ack (ack_vec),
    .cmd (cmd_q),
    .pri (sta_pri),
    .sec (sta_sec),
    .pos (pos_q),
    .on  (on_q),
    .hit (hit)
  );

  pds_poll_timer #(
    .POLL_CYCLES (POLL_CYCLES),
    .MAX_POLLS   (MAX_POLLS)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (state_q == ST_WAIT),
    .tick  (tick),
    .last  (last)
  );

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cmd_q   <= '0;
      pend_q  <= '0;
      pos_q   <= '0;
      on_q    <= 1'b0;
      en_q    <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            if (dec_ok) begin
              pend_q  <= dec_cmd;
              pos_q   <= dec_pos;
              on_q    <= req_on;
              en_q    <= 1'b1;
              state_q <= ST_ARM;
            end else begin
              err_q <= 1'b1;
            end
          end
        end
        ST_ARM: begin
          cmd_q   <= pend_q;
          state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (tick && (hit || last)) begin
            done_q  <= hit;
            err_q   <= !hit;
            cmd_q   <= '0;
            en_q    <= 1'b0;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cmd_vec = cmd_q;
  assign ctrl_en = en_q;
  assign done    = done_q;
  assign err     = err_q;

  // R2: at most one command bit
  a_r2_cmd_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd_vec));
  // R3: a command is never driven without the enable
  a_r3_cmd_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vec != '0) |-> ctrl_en);
  // R3: enable already high the cycle before a command appears
  a_r3_en_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|cmd_vec) |-> $past(ctrl_en));
  // R8: outcomes exclusive
  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));
  // R8: outcome cycle has command and enable cleared
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (done || err) |-> (cmd_vec == '0 && !ctrl_en));
  // R8: done lasts one cycle
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R5: success only after the engine echoed the command
  a_r5_done_echo: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(|(ack_vec & cmd_vec)));
  // R1: not ready while a request is in flight
  a_r1_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_en |-> !req_ready);
endmodule

// File: tb/pwr_domain_seq_tb.sv
module pwr_domain_seq_tb;
  localparam int P  = 4;
  localparam int MX = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  req_dom = '0;
  logic        req_on = 1'b0;
  logic [19:0] ack_vec = '0;
  logic [31:0] sta_pri = '0;
  logic [31:0] sta_sec = '0;
  logic [19:0] cmd_vec;
  logic        ctrl_en, done, err;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  pwr_domain_seq #(.POLL_CYCLES(P), .MAX_POLLS(MX)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_dom(req_dom), .req_on(req_on), .ack_vec(ack_vec), .sta_pri(sta_pri),
    .sta_sec(sta_sec), .cmd_vec(cmd_vec), .ctrl_en(ctrl_en), .done(done), .err(err)
  );

  function automatic int exp_pos(input int d);
    int t[10] = '{7, 21, 5, 3, 20, 24, 23, 22, 4, 25};
    return t[d];
  endfunction

  function automatic logic [19:0] exp_cmd(input int d, input bit on);
    logic [19:0] v = '0;
    v[on ? d : d + 10] = 1'b1;
    return v;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // bad: 0 none, 1 no echo, 2 primary wrong, 3 secondary wrong
  task automatic drive_engine(input int d, input bit on, input int bad);
    logic [19:0] c = exp_cmd(d, on);
    logic [31:0] p = $urandom;
    logic [31:0] s = $urandom;
    logic [19:0] a = 20'($urandom);
    int          k = exp_pos(d);
    p[k] = on;
    s[k] = on;
    a = a | c;
    if (bad == 1) a = a & ~c;
    if (bad == 2) p[k] = ~on;
    if (bad == 3) s[k] = ~on;
    ack_vec = a;
    sta_pri = p;
    sta_sec = s;
  endtask

  // scen: 0 good, 1..3 bad kind, 4 late (good after sample k)
  task automatic run_req(input int d, input bit on, input int scen, input int k, input bit inject);
    int  n;
    bit  ok;
    @(negedge clk);
    if (d < 10) drive_engine(d, on, (scen == 4) ? (k % 3) + 1 : scen);
    req_dom   = 4'(d);
    req_on    = on;
    req_valid = 1'b1;
    @(posedge clk); #1;
    req_valid = 1'b0;
    if (d >= 10) begin
      chk(err && !done && cmd_vec == 0 && !ctrl_en, "R9 bad index err", {err, ctrl_en}, 2'b10);
      @(posedge clk); #1;
      chk(!err && req_ready && cmd_vec == 0, "R9 no command after", cmd_vec, 0);
      return;
    end
    chk(ctrl_en && cmd_vec == 0 && !req_ready, "R3 enable before command", {ctrl_en, cmd_vec}, 21'h100000);
    @(posedge clk); #1;
    chk(cmd_vec == exp_cmd(d, on) && ctrl_en, "R2 command encoding", cmd_vec, exp_cmd(d, on));
    if (scen == 0) begin n = 1; ok = 1; end
    else if (scen == 4 && k <= MX) begin n = k + 1; ok = 1; end
    else begin n = MX + 1; ok = 0; end
    for (int c = 1; c <= n * P; c++) begin
      if (inject && c == 1) begin
        req_dom   = 4'((d + 1) % 10);
        req_on    = ~on;
        req_valid = 1'b1;
      end
      @(posedge clk); #1;
      req_valid = 1'b0;
      if (c < n * P) begin
        chk(!done && !err, "R6 no early outcome", {done, err}, 0);
        if (inject && c == 1)
          chk(cmd_vec == exp_cmd(d, on), "R1 busy request ignored", cmd_vec, exp_cmd(d, on));
        if (scen == 4 && c == k * P) drive_engine(d, on, 0);
      end else begin
        if (ok) chk(done && !err, "R5 R6 done on expected sample", {done, err}, 2'b10);
        else    chk(err && !done, "R7 timeout err", {done, err}, 2'b01);
        chk(cmd_vec == 0 && !ctrl_en && req_ready, "R8 cleared at outcome", {ctrl_en, cmd_vec}, 0);
      end
    end
    @(posedge clk); #1;
    chk(!done && !err, "R8 single-cycle pulse", {done, err}, 0);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    void'($urandom(32'd5813));
    repeat (3) @(posedge clk);
    #1;
    chk(req_ready && cmd_vec == 0 && !ctrl_en && !done && !err, "R10 reset state",
        {req_ready, ctrl_en, done, err}, 4'b1000);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk(req_ready && cmd_vec == 0 && !ctrl_en, "R10 idle after reset", cmd_vec, 0);

    run_req(0, 1'b1, 0, 0, 1'b0);   // R2 lowest on bit
    run_req(9, 1'b0, 0, 0, 1'b0);   // R2 highest off bit (19)
    for (int d = 0; d < 10; d++) run_req(d, d[0], 0, 0, 1'b0);  // R4 each position
    run_req(3, 1'b1, 1, 0, 1'b0);   // R5 missing echo
    run_req(5, 1'b0, 2, 0, 1'b0);   // R5 primary mismatch
    run_req(8, 1'b1, 3, 0, 1'b0);   // R5 secondary mismatch
    for (int k = 1; k <= MX + 1; k++) run_req(2, 1'b1, 4, k, 1'b0);  // R6 / R7 edges
    run_req(10, 1'b1, 0, 0, 1'b0);  // R9
    run_req(15, 1'b0, 0, 0, 1'b0);  // R9
    run_req(6, 1'b1, 0, 0, 1'b1);   // R1 dropped request
    run_req(4, 1'b0, 4, 1, 1'b1);   // R1 during longer wait

    for (int i = 0; i < 60; i++) begin
      int d    = ($urandom_range(0, 9) == 0) ? $urandom_range(10, 15) : $urandom_range(0, 9);
      int scen = $urandom_range(0, 4);
      run_req(d, 1'($urandom), scen, $urandom_range(1, MX + 1), 1'($urandom_range(0, 3) == 0));
    end
    summary();
  end
endmodule